// File: doc/BRIEF.md
# Counted Pulse Sequence Generator

This block produces square-wave pulse trains paced by a single-cycle strobe that marks each ADC conversion clock in the system clock domain. A phase counter divides that strobe into cycles of 16 or 8 strobes, and every cycle is one pulse: high during the first half, low during the second. A pulse counter sets how many pulses a burst contains. The pulse stage can also run without end, and the phase stage can be set to run whenever the ADC is powered rather than only while pulses are in progress.

The pulse waveform reaches four outputs. Each output has its own enable and its own polarity bit. A disabled output rests at its inactive level. Software reaches the block through a small word-addressed register bus. There is one configuration word and one control word. The control word has a direct-write address plus OR-in and clear-out aliases, and it reports a read-only busy flag.

Top module: `seq_pulse_gen`

## Requirements
- R1: After a synchronous reset, all outputs and `busy` are 0, and reads of offset 0x00 and offset 0x10 return 0.
- R2: Writing offset 0x00 with a non-zero count in bits 11:0 and bit 14 clear starts a burst. A new write restarts the phase from the start of a pulse. The burst gives exactly that many pulses, each high for half a cycle. `busy` stays 1 for exactly count × cycle strobes and then returns to 0.
- R3: Configuration bit 12 selects the cycle length. A 0 gives 16 strobes per cycle and a 1 gives 8.
- R4: A count of zero written with bit 14 clear starts no burst, and `busy` stays 0.
- R5: With configuration bit 14 set, the count is ignored and pulses repeat without end, but only while at least one output enable is set. When all enables are cleared, `busy` drops to 0.
- R6: With configuration bit 13 set, the phase counter advances only while `adc_on` is high, so a burst stalls while `adc_on` is low. With bit 13 clear, the phase counter advances during pulse generation whatever the level of `adc_on`.
- R7: Control bits 3:0 invert outputs 0 to 3, and control bits 7:4 enable them. An enabled output carries the waveform XOR its invert bit. A disabled output is held at its invert bit.
- R8: A write to offset 0x10 loads the control bits. A write to 0x14 ORs the data into them, and a write to 0x18 clears every bit that is 1 in the data.
- R9: Control bit 8 reads back `busy` and ignores writes at all three control addresses. Offset 0x00 reads back the configuration last written. Read data appears one cycle after the address.
- R10: The phase counter and the pulse counter change only in cycles where `adc_tick` is high, apart from a configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| adc_tick | input | 1 | One-cycle strobe per ADC conversion clock |
| adc_on | input | 1 | High while the ADC is powered |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pulse_out | output | 4 | Gated, polarity-adjusted pulse outputs |
| busy | output | 1 | High while the pulse counter is running |

## Verification
If the pulse counter loses or gains a step, the length of the `busy` window changes by a whole cycle of 8 or 16 strobes. The bench measures that window exactly at the end of every burst. A phase counter that runs at the wrong moment, or past its cycle length, changes the number of active-level samples on each output within one cycle. A wrong control-alias merge shows up in the next control read one cycle later. A disabled output that leaks the waveform differs from its invert level at the next edge after the pulse goes high.

// File: rtl/seq_pkg.sv
package seq_pkg;
  // byte offsets of the register words
  localparam int unsigned OFS_CFG     = 'h00;
  localparam int unsigned OFS_CTL     = 'h10;
  localparam int unsigned OFS_CTL_SET = 'h14;
  localparam int unsigned OFS_CTL_CLR = 'h18;

  typedef enum logic [1:0] {
    CTL_LOAD = 2'd0,
    CTL_OR   = 2'd1,
    CTL_AND_NOT = 2'd2,
    CTL_NONE = 2'd3
  } ctl_op_e;
endpackage

// File: rtl/seq_regs.sv
module seq_regs
  import seq_pkg::*;
#(
  parameter int COUNT_W = 12,
  parameter int NUM_OUT = 4,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               busy,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               cfg_wr,
  output logic [COUNT_W-1:0] wr_count,
  output logic               wr_pfree,
  output logic [COUNT_W-1:0] cfg_count,
  output logic               cfg_fast,
  output logic               cfg_phfree,
  output logic               cfg_pfree,
  output logic [NUM_OUT-1:0] ctl_inv,
  output logic [NUM_OUT-1:0] ctl_en
);
  localparam int CTL_W  = 2 * NUM_OUT;
  localparam int FAST_B = COUNT_W;
  localparam int PHF_B  = COUNT_W + 1;
  localparam int PF_B   = COUNT_W + 2;
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTL);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFS_CTL_SET);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_CTL_CLR);

  logic [CTL_W-1:0] ctl_q;
  logic [CTL_W-1:0] wbits;
  ctl_op_e          op;
  logic [DATA_W-1:0] rd_n;

  assign cfg_wr   = bus_wr && (bus_addr == A_CFG);
  assign wr_count = bus_wdata[COUNT_W-1:0];
  assign wr_pfree = bus_wdata[PF_B];
  assign wbits    = bus_wdata[CTL_W-1:0];
  assign ctl_inv  = ctl_q[NUM_OUT-1:0];
  assign ctl_en   = ctl_q[CTL_W-1:NUM_OUT];

  always_comb begin
    op = CTL_NONE;
    if (bus_wr) begin
      if (bus_addr == A_CTL)      op = CTL_LOAD;
      else if (bus_addr == A_SET) op = CTL_OR;
      else if (bus_addr == A_CLR) op = CTL_AND_NOT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_count  <= '0;
      cfg_fast   <= 1'b0;
      cfg_phfree <= 1'b0;
      cfg_pfree  <= 1'b0;
      ctl_q      <= '0;
    end else begin
      if (cfg_wr) begin
        cfg_count  <= wr_count;
        cfg_fast   <= bus_wdata[FAST_B];
        cfg_phfree <= bus_wdata[PHF_B];
        cfg_pfree  <= wr_pfree;
      end
      case (op)
        CTL_LOAD:    ctl_q <= wbits;
        CTL_OR:      ctl_q <= ctl_q | wbits;
        CTL_AND_NOT: ctl_q <= ctl_q & ~wbits;
        default:     ctl_q <= ctl_q;
      endcase
    end
  end

  always_comb begin
    rd_n = '0;
    if (bus_addr == A_CFG) begin
      rd_n[COUNT_W-1:0] = cfg_count;
      rd_n[FAST_B]      = cfg_fast;
      rd_n[PHF_B]       = cfg_phfree;
      rd_n[PF_B]        = cfg_pfree;
    end else if (bus_addr == A_CTL || bus_addr == A_SET || bus_addr == A_CLR) begin
      rd_n[CTL_W-1:0] = ctl_q;
      rd_n[CTL_W]     = busy;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_n;
  end
endmodule

// File: rtl/seq_engine.sv
module seq_engine #(
  parameter int COUNT_W  = 12,
  parameter int NUM_OUT  = 4,
  parameter int SLOW_LEN = 16,
  parameter int FAST_LEN = 8,
  localparam int PH_W    = $clog2(SLOW_LEN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adc_tick,
  input  logic               adc_on,
  input  logic               cfg_wr,
  input  logic [COUNT_W-1:0] wr_count,
  input  logic               wr_pfree,
  input  logic               cfg_fast,
  input  logic               cfg_phfree,
  input  logic               cfg_pfree,
  input  logic [NUM_OUT-1:0] ctl_en,
  output logic [PH_W-1:0]    ph_cnt,
  output logic [COUNT_W-1:0] rem_cnt,
  output logic               active,
  output logic               wave
);
  localparam logic [PH_W-1:0] SLOW_LAST = PH_W'(SLOW_LEN - 1);
  localparam logic [PH_W-1:0] FAST_LAST = PH_W'(FAST_LEN - 1);
  localparam logic [PH_W-1:0] SLOW_HALF = PH_W'(SLOW_LEN / 2);
  localparam logic [PH_W-1:0] FAST_HALF = PH_W'(FAST_LEN / 2);

  logic [PH_W-1:0] last_ph;
  logic [PH_W-1:0] half_ph;
  logic            ph_run;
  logic            wrap;

  assign last_ph = cfg_fast ? FAST_LAST : SLOW_LAST;
  assign half_ph = cfg_fast ? FAST_HALF : SLOW_HALF;
  assign active  = (rem_cnt != '0) || (cfg_pfree && (|ctl_en));
  assign ph_run  = adc_tick && (cfg_phfree ? adc_on : active);
  assign wrap    = (ph_cnt == last_ph);
  assign wave    = active && (ph_cnt < half_ph);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_cnt  <= '0;
      rem_cnt <= '0;
    end else if (cfg_wr) begin
      ph_cnt  <= '0;
      rem_cnt <= wr_pfree ? '0 : wr_count;
    end else if (ph_run) begin
      ph_cnt <= wrap ? '0 : ph_cnt + 1'b1;
      if (wrap && rem_cnt != '0) rem_cnt <= rem_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/seq_outstage.sv
module seq_outstage #(
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wave,
  input  logic [NUM_OUT-1:0] ctl_en,
  input  logic [NUM_OUT-1:0] ctl_inv,
  output logic [NUM_OUT-1:0] pulse_out
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) pulse_out[i] <= 1'b0;
      else     pulse_out[i] <= ctl_en[i] ? (wave ^ ctl_inv[i]) : ctl_inv[i];
    end
  end
endmodule

// File: rtl/seq_pulse_gen.sv
module seq_pulse_gen #(
  parameter int COUNT_W  = 12,
  parameter int NUM_OUT  = 4,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int SLOW_LEN = 16,
  parameter int FAST_LEN = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adc_tick,
  input  logic               adc_on,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [NUM_OUT-1:0] pulse_out,
  output logic               busy
);
  localparam int PH_W = $clog2(SLOW_LEN);

  logic               cfg_wr;
  logic [COUNT_W-1:0] wr_count;
  logic               wr_pfree;
  logic [COUNT_W-1:0] cfg_count;
  logic               cfg_fast;
  logic               cfg_phfree;
  logic               cfg_pfree;
  logic [NUM_OUT-1:0] ctl_inv;
  logic [NUM_OUT-1:0] ctl_en;
  logic [PH_W-1:0]    ph_cnt;
  logic [COUNT_W-1:0] rem_cnt;
  logic               wave;

  seq_regs #(
    .COUNT_W(COUNT_W), .NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) regs_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(busy), .bus_rdata(bus_rdata),
    .cfg_wr(cfg_wr), .wr_count(wr_count), .wr_pfree(wr_pfree),
    .cfg_count(cfg_count), .cfg_fast(cfg_fast), .cfg_phfree(cfg_phfree),
    .cfg_pfree(cfg_pfree), .ctl_inv(ctl_inv), .ctl_en(ctl_en)
  );

  seq_engine #(
    .COUNT_W(COUNT_W), .NUM_OUT(NUM_OUT), .SLOW_LEN(SLOW_LEN), .FAST_LEN(FAST_LEN)
  ) engine_i (
    .clk(clk), .rst(rst), .adc_tick(adc_tick), .adc_on(adc_on),
    .cfg_wr(cfg_wr), .wr_count(wr_count), .wr_pfree(wr_pfree),
    .cfg_fast(cfg_fast), .cfg_phfree(cfg_phfree), .cfg_pfree(cfg_pfree),
    .ctl_en(ctl_en), .ph_cnt(ph_cnt), .rem_cnt(rem_cnt), .active(busy),
    .wave(wave)
  );

  seq_outstage #(.NUM_OUT(NUM_OUT)) outs_i (
    .clk(clk), .rst(rst), .wave(wave), .ctl_en(ctl_en), .ctl_inv(ctl_inv),
    .pulse_out(pulse_out)
  );
endmodule

// File: rtl/seq_pulse_gen_chk.sv
module seq_pulse_gen_chk #(
  parameter int COUNT_W  = 12,
  parameter int NUM_OUT  = 4,
  parameter int DATA_W   = 32,
  parameter int SLOW_LEN = 16,
  parameter int FAST_LEN = 8,
  localparam int PH_W    = $clog2(SLOW_LEN)
) (
  input logic               clk,
  input logic               rst,
  input logic               adc_tick,
  input logic               adc_on,
  input logic               cfg_wr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               cfg_fast,
  input logic               cfg_phfree,
  input logic [NUM_OUT-1:0] ctl_en,
  input logic [NUM_OUT-1:0] ctl_inv,
  input logic [NUM_OUT-1:0] pulse_out,
  input logic [PH_W-1:0]    ph_cnt,
  input logic [COUNT_W-1:0] rem_cnt,
  input logic               busy
);
  // R7
  gated_lane_chk: assert property (@(posedge clk) disable iff (rst)
    ((pulse_out ^ $past(ctl_inv)) & ~$past(ctl_en)) == '0);

  // R2
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(busy) |-> (pulse_out == $past(ctl_inv)));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_wr) |-> (rem_cnt == $past(rem_cnt)) || (rem_cnt == $past(rem_cnt) - 1'b1));

  // R10
  tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(adc_tick) && !$past(cfg_wr)) |-> (ph_cnt == $past(ph_cnt)) && (rem_cnt == $past(rem_cnt)));

  // R3
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    ph_cnt <= (cfg_fast ? PH_W'(FAST_LEN - 1) : PH_W'(SLOW_LEN - 1)));

  // R4
  zero_count_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_wr && (bus_wdata[COUNT_W-1:0] == '0) && !bus_wdata[COUNT_W+2]) |-> !busy);

  // R6
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_phfree && !adc_on && !cfg_wr) |-> (ph_cnt == $past(ph_cnt)));
endmodule

bind seq_pulse_gen seq_pulse_gen_chk #(
  .COUNT_W(COUNT_W), .NUM_OUT(NUM_OUT), .DATA_W(DATA_W),
  .SLOW_LEN(SLOW_LEN), .FAST_LEN(FAST_LEN)
) chk_i (
  .clk(clk), .rst(rst), .adc_tick(adc_tick), .adc_on(adc_on), .cfg_wr(cfg_wr),
  .bus_wdata(bus_wdata), .cfg_fast(cfg_fast), .cfg_phfree(cfg_phfree),
  .ctl_en(ctl_en), .ctl_inv(ctl_inv), .pulse_out(pulse_out), .ph_cnt(ph_cnt),
  .rem_cnt(rem_cnt), .busy(busy)
);

// File: tb/seq_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module seq_pulse_gen_tb_top;
  localparam real CLK_NS = 8.0;
  localparam int  NV = 4;
  // {count[20:9], fast[8], inv[7:4], en[3:0]}
  localparam logic [20:0] VEC [NV] = '{
    {12'd3, 1'b0, 4'h0, 4'h1},
    {12'd5, 1'b1, 4'h2, 4'h3},
    {12'd1, 1'b0, 4'hF, 4'h8},
    {12'd7, 1'b1, 4'h4, 4'hF}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adc_tick = 1'b0;
  logic        adc_on = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pulse_out;
  logic        busy;
  logic        tick_alt = 1'b0;
  int checks = 0;
  int errors = 0;

  seq_pulse_gen dut_i (
    .clk(clk), .rst(rst), .adc_tick(adc_tick), .adc_on(adc_on),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pulse_out(pulse_out), .busy(busy)
  );

  always #(CLK_NS / 2.0) clk = ~clk;

  initial forever begin
    @(negedge clk);
    adc_tick = tick_alt ? ~adc_tick : 1'b1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic run_burst(input int n, input bit fast, input logic [3:0] inv,
                           input logic [3:0] en, input string req);
    int len;
    int busy_n;
    int act_n [4];
    len = fast ? 8 : 16;
    busy_n = 0;
    for (int i = 0; i < 4; i++) act_n[i] = 0;
    wr(5'h10, {24'd0, en, inv});
    wr(5'h00, {19'd0, fast, n[11:0]});
    for (int k = 0; k < n * len + 6; k++) begin
      if (busy) busy_n++;
      for (int i = 0; i < 4; i++) if (pulse_out[i] != inv[i]) act_n[i]++;
      @(negedge clk);
    end
    check({req, " busy window"}, busy_n, n * len);
    for (int i = 0; i < 4; i++)
      check({req, " R7 active samples"}, act_n[i], en[i] ? n * len / 2 : 0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    int edges;
    logic prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 outputs", int'(pulse_out), 0);
    check("R1 busy", int'(busy), 0);
    rd(5'h00, d); check("R1 cfg read", int'(d), 0);
    rd(5'h10, d); check("R1 ctl read", int'(d), 0);

    // R2 R3 R7: vector table, phase stage not free-running, adc_on low
    for (int v = 0; v < NV; v++)
      run_burst(int'(VEC[v][20:9]), VEC[v][8], VEC[v][7:4], VEC[v][3:0],
                VEC[v][8] ? "R3 fast" : "R2 R6 slow");

    // R8 alias writes, R9 status ignores writes
    wr(5'h10, 32'h0);
    wr(5'h14, 32'h0F); rd(5'h10, d); check("R8 set alias", int'(d), 'h0F);
    wr(5'h18, 32'h05); rd(5'h18, d); check("R8 clear alias", int'(d), 'h0A);
    wr(5'h10, 32'h1FF); rd(5'h10, d); check("R9 status write ignored", int'(d), 'hFF);
    wr(5'h14, 32'h100); rd(5'h10, d); check("R9 status set ignored", int'(d), 'hFF);

    // R9 status and config readback during a burst
    wr(5'h10, 32'h10);
    wr(5'h00, 32'h0000_1002);
    rd(5'h10, d); check("R9 busy bit", int'(d[8]), 1);
    rd(5'h00, d); check("R9 cfg readback", int'(d), 'h1002);
    repeat (40) @(negedge clk);
    rd(5'h10, d); check("R9 idle bit", int'(d[8]), 0);

    // R4 zero count
    wr(5'h00, 32'h0000_0000);
    repeat (20) @(negedge clk);
    check("R4 busy", int'(busy), 0);
    check("R4 out0", int'(pulse_out[0]), 0);

    // R5 pulse free-run
    wr(5'h10, 32'h0);
    wr(5'h00, 32'h0000_5000);
    repeat (4) @(negedge clk);
    check("R5 no enables idle", int'(busy), 0);
    wr(5'h14, 32'h10);
    check("R5 running", int'(busy), 1);
    edges = 0; prev = pulse_out[0];
    for (int k = 0; k < 80; k++) begin
      if (pulse_out[0] && !prev) edges++;
      prev = pulse_out[0];
      @(negedge clk);
    end
    check("R5 continuous pulses", int'(edges >= 9 && edges <= 11), 1);
    wr(5'h18, 32'hF0);
    check("R5 stop on disable", int'(busy), 0);
    repeat (2) @(negedge clk);
    check("R5 out0 idle", int'(pulse_out[0]), 0);

    // R6 phase free-run stalls while adc_on is low
    wr(5'h10, 32'h10);
    wr(5'h00, 32'h0000_3002);
    n = 0;
    for (int k = 0; k < 40; k++) begin
      if (busy) n++;
      @(negedge clk);
    end
    check("R6 stalled", n, 40);
    adc_on = 1'b1;
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
    check("R6 resumes", n, 16);
    adc_on = 1'b0;

    // R10 strobe every other cycle doubles the burst
    tick_alt = 1'b1;
    wr(5'h00, 32'h0000_1001);
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
    check("R10 half-rate window", int'(n >= 15 && n <= 16), 1);
    tick_alt = 1'b0;

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule